// File: doc/BRIEF.md
# Relative Branch Target Generator

This block examines one 32-bit fixed-width instruction word at a time and, when the word encodes a PC-relative branch, produces the destination address, a taken decision and a link request. The branch immediate counts words rather than bytes, so the block multiplies it by four, sign-extends it to the address width and adds it to a prefetch-adjusted program counter. The decision comes from the condition field, which is checked against the negative, zero, carry and overflow status flags.

A caller presents `instr`, `pc` (the address of the word) and the flags together with `in_valid`. One clock later the registered result appears with `out_valid`. A two-state controller tracks whether a result is on the outputs. Its states are ST_IDLE (no result shown) and ST_RESULT (a result shown for this cycle). Its transitions are T_ACCEPT (ST_IDLE to ST_RESULT on a strobe), T_STREAM (ST_RESULT stays on a strobe), T_DRAIN (ST_RESULT to ST_IDLE with no strobe) and T_WAIT (ST_IDLE stays with no strobe). Between strobes the payload outputs keep their last values.

Top module: `branch_target_gen`

## Requirements
- R1: `out_valid` is 1 in exactly the cycle after each cycle with `in_valid` = 1 and 0 otherwise. Reset drives `out_valid`, `taken`, `link_req` and `target` to 0.
- R2: A word is a branch only when bits 27:25 equal 3'b101. For any other word, `taken` and `link_req` are 0.
- R3: `target` = (`pc` with bits 1:0 cleared) + 8 + (sign-extended bits 23:0 of `instr`) × 4.
- R4: Bits 1:0 of `target` are always 0, and bits 1:0 of `pc` have no effect on the result.
- R5: Condition codes in bits 31:28 are evaluated as follows. 0 needs Z. 1 needs !Z. 2 needs C. 3 needs !C. 4 needs N. 5 needs !N. 6 needs V. 7 needs !V. 8 needs C&!Z. 9 needs !C|Z. 10 needs N==V. 11 needs N!=V. 12 needs !Z&(N==V). 13 needs Z|(N!=V). A branch is taken only when its condition holds.
- R6: Code 14 makes a branch taken whatever the flags. Code 15 makes it not taken whatever the flags.
- R7: `link_req` is 1 exactly when `taken` is 1 and bit 24 of the word is 1.
- R8: While `in_valid` is 0, `target`, `taken` and `link_req` keep their values.
- R9: The addition wraps modulo 2^32, which gives reach in both directions across address 0. The extreme immediates 0x7FFFFF and 0x800000 move the target by +(2^25 − 4) and −2^25 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word and flags are present this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Byte address of the instruction word |
| flag_n | input | 1 | Negative status flag |
| flag_z | input | 1 | Zero status flag |
| flag_c | input | 1 | Carry status flag |
| flag_v | input | 1 | Overflow status flag |
| out_valid | output | 1 | Registered result is present |
| target | output | 32 | Branch destination address |
| taken | output | 1 | Branch executes |
| link_req | output | 1 | Return address is to be written to the link register |

## Verification
The hardest situations to reach are the wrap of the sum across address 0 combined with the most negative and most positive immediates, and each of the sixteen condition codes under every flag combination. Random words almost never land on these. The stimulus therefore places program counters just below 2^32 and just above 0 with the extreme immediates, and sweeps all 256 pairs of condition code and flag nibble. Non-branch group values and unaligned program counters are included in the same scoreboarded stream. Idle gaps with changing inputs show that the outputs hold between strobes.

// File: rtl/brt_pkg.sv
package brt_pkg;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned IMM_W     = 24;
    localparam int unsigned SHIFT     = 2;
    localparam int unsigned PREFETCH  = 8;
    localparam logic [2:0]  GRP_BRANCH = 3'b101;

    typedef enum logic [3:0] {
        CC_EQ, CC_NE, CC_CS, CC_CC, CC_MI, CC_PL, CC_VS, CC_VC,
        CC_HI, CC_LS, CC_GE, CC_LT, CC_GT, CC_LE, CC_AL, CC_NV
    } cond_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESULT
    } ctl_state_e;

    typedef struct packed {
        logic              taken;
        logic              link;
        logic [ADDR_W-1:0] target;
    } brt_result_t;
endpackage

// File: rtl/brt_decode.sv
module brt_decode
    import brt_pkg::*;
(
    input  logic [31:0]      word,
    output cond_e            cond,
    output logic             is_branch,
    output logic             link_bit,
    output logic [IMM_W-1:0] imm
);
    always_comb begin
        cond      = cond_e'(word[31:28]);
        is_branch = (word[27:25] == GRP_BRANCH);
        link_bit  = word[24];
        imm       = word[IMM_W-1:0];
    end
endmodule

// File: rtl/brt_cond_eval.sv
module brt_cond_eval
    import brt_pkg::*;
(
    input  cond_e cond,
    input  logic  n,
    input  logic  z,
    input  logic  c,
    input  logic  v,
    output logic  pass
);
    logic ge;
    always_comb begin
        ge = (n == v);
        unique case (cond)
            CC_EQ: pass = z;
            CC_NE: pass = !z;
            CC_CS: pass = c;
            CC_CC: pass = !c;
            CC_MI: pass = n;
            CC_PL: pass = !n;
            CC_VS: pass = v;
            CC_VC: pass = !v;
            CC_HI: pass = c && !z;
            CC_LS: pass = !c || z;
            CC_GE: pass = ge;
            CC_LT: pass = !ge;
            CC_GT: pass = !z && ge;
            CC_LE: pass = z || !ge;
            CC_AL: pass = 1'b1;
            CC_NV: pass = 1'b0;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/brt_target_calc.sv
module brt_target_calc
    import brt_pkg::*;
#(
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned IW    = IMM_W,
    parameter int unsigned SH    = SHIFT,
    parameter int unsigned AHEAD = PREFETCH
) (
    input  logic [AW-1:0] pc,
    input  logic [IW-1:0] imm,
    output logic [AW-1:0] target
);
    localparam int unsigned SCALED_W = IW + SH;
    localparam int unsigned EXT_W    = AW - SCALED_W;
    localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << SH) - AW'(1));

    logic [AW-1:0] base;
    logic [AW-1:0] offset;

    generate
        if (EXT_W > 0) begin : g_ext
            assign offset = {{EXT_W{imm[IW-1]}}, imm, {SH{1'b0}}};
        end else begin : g_trunc
            assign offset = AW'({imm, {SH{1'b0}}});
        end
    endgenerate

    always_comb begin
        base   = (pc & ALIGN_MASK) + AW'(AHEAD);
        target = (base + offset) & ALIGN_MASK;
    end
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
    import brt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [31:0] pc,
    input  logic        flag_n,
    input  logic        flag_z,
    input  logic        flag_c,
    input  logic        flag_v,
    output logic        out_valid,
    output logic [31:0] target,
    output logic        taken,
    output logic        link_req
);
    cond_e            dec_cond;
    logic             dec_branch;
    logic             dec_link;
    logic [IMM_W-1:0] dec_imm;
    logic             cond_pass;
    logic [ADDR_W-1:0] calc_target;

    ctl_state_e  state_q, state_d;
    brt_result_t res_d, res_q;

    brt_decode u_decode (
        .word      (instr),
        .cond      (dec_cond),
        .is_branch (dec_branch),
        .link_bit  (dec_link),
        .imm       (dec_imm)
    );

    brt_cond_eval u_cond (
        .cond (dec_cond),
        .n    (flag_n),
        .z    (flag_z),
        .c    (flag_c),
        .v    (flag_v),
        .pass (cond_pass)
    );

    brt_target_calc u_calc (
        .pc     (pc),
        .imm    (dec_imm),
        .target (calc_target)
    );

    always_comb begin
        res_d.taken  = dec_branch && cond_pass;
        res_d.link   = dec_branch && cond_pass && dec_link;
        res_d.target = calc_target;
    end

    // Next-state logic: T_ACCEPT, T_STREAM, T_DRAIN, T_WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register: loads on every accepted word, holds otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (in_valid) begin
            res_q <= res_d;
        end
    end

    assign out_valid = (state_q == ST_RESULT);
    assign target    = res_q.target;
    assign taken     = res_q.taken;
    assign link_req  = res_q.link;
endmodule

// File: rtl/brt_checker.sv
module brt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [3:0] cond,
    input logic [2:0] grp,
    input logic       out_valid,
    input logic [1:0] tgt_low,
    input logic       taken,
    input logic       link_req
);
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_nonbranch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && grp != 3'b101) |=> (!taken && !link_req));
    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (tgt_low == 2'b00));
    p_always_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && grp == 3'b101 && cond == 4'hE) |=> taken);
    p_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond == 4'hF) |=> !taken);
    p_link_implies_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_req |-> taken);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(taken) && $stable(link_req) && $stable(tgt_low)));
endmodule

bind branch_target_gen brt_checker u_brt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cond      (instr[31:28]),
    .grp       (instr[27:25]),
    .out_valid (out_valid),
    .tgt_low   (target[1:0]),
    .taken     (taken),
    .link_req  (link_req)
);

// File: tb/branch_target_gen_test.sv
module branch_target_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
    logic        out_valid;
    logic [31:0] target;
    logic        taken;
    logic        link_req;

    typedef struct {
        logic [31:0] tgt;
        logic        tk;
        logic        lk;
        logic        chk_tgt;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    logic [31:0] last_tgt = '0;
    logic        last_tk = 1'b0, last_lk = 1'b0;

    always #5 clk = ~clk;

    branch_target_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .out_valid(out_valid), .target(target), .taken(taken), .link_req(link_req)
    );

    function automatic logic ref_cond(input logic [3:0] cc, input logic [3:0] nzcv);
        logic n, z, c, v;
        {n, z, c, v} = nzcv;
        case (cc)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c & !z;
            4'd9:  return !c | z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z & (n == v);
            4'd13: return z | (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies one word and pushes the expected result
    task automatic drive(input logic [31:0] w, input logic [31:0] p,
                         input logic [3:0] nzcv, input string tag);
        exp_t e;
        logic br, tk;
        logic [31:0] off;
        @(negedge clk);
        instr = w; pc = p; {flag_n, flag_z, flag_c, flag_v} = nzcv; in_valid = 1'b1;
        br    = (w[27:25] == 3'b101);
        tk    = br && ref_cond(w[31:28], nzcv);
        off   = {{6{w[23]}}, w[23:0], 2'b00};
        e.tgt = {p[31:2], 2'b00} + 32'd8 + off;
        e.tk  = tk;
        e.lk  = tk && w[24];
        e.chk_tgt = 1'b1;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            instr = $urandom; pc = $urandom; {flag_n, flag_z, flag_c, flag_v} = 4'($urandom);
        end
    endtask

    // Monitor: pops and compares whenever a result is shown
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected out_valid", 32'(out_valid), 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " target"}, target, e.tgt);
                    check({e.tag, " taken"}, 32'(taken), 32'(e.tk));
                    check({e.tag, " link R7"}, 32'(link_req), 32'(e.lk));
                    check({e.tag, " R4 low bits"}, 32'(target[1:0]), 32'd0);
                end
                last_tgt = target; last_tk = taken; last_lk = link_req;
            end else if (total > 0) begin
                check("R8 hold target", target, last_tgt);
                check("R8 hold taken/link", {30'd0, taken, link_req}, {30'd0, last_tk, last_lk});
            end
        end
    end

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", 32'(out_valid), 32'd0);
        check("R1 reset target", target, 32'd0);
        check("R1 reset taken/link", {30'd0, taken, link_req}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R3 forward / backward, R9 extremes and wrap
        drive(32'hEA00_0010, 32'h0000_1000, 4'h0, "R3 forward");
        drive(32'hEAFF_FFF0, 32'h0000_1000, 4'h0, "R3 backward");
        drive(32'hEA7F_FFFF, 32'h0100_0000, 4'h0, "R9 max positive");
        drive(32'hEA80_0000, 32'h0400_0000, 4'h0, "R9 max negative");
        drive(32'hEA00_0004, 32'hFFFF_FFF0, 4'h0, "R9 wrap upward");
        drive(32'hEAFF_FFF0, 32'h0000_0010, 4'h0, "R9 wrap downward");
        drive(32'hEA80_0000, 32'h0000_0000, 4'h0, "R9 min from zero");
        drive(32'hEA00_0001, 32'h0000_2003, 4'h0, "R4 unaligned pc");
        drive(32'hEBFF_FFFE, 32'h0000_3000, 4'h0, "R7 link always");
        idle(3);

        // R2 non-branch groups, with and without bit 24
        for (int g = 0; g < 8; g++) begin
            drive({4'hE, 3'(g), 1'b1, 24'h000040}, 32'h0000_8000, 4'hF, "R2 group sweep");
        end
        idle(2);

        // R5 / R6 all codes against all flag nibbles
        for (int cc = 0; cc < 16; cc++) begin
            for (int f = 0; f < 16; f++) begin
                drive({4'(cc), 3'b101, f[0], 24'h000100}, 32'h0000_4000, 4'(f),
                      (cc >= 14) ? "R6 always/never" : "R5 cond sweep");
            end
            idle(1);
        end

        // Mixed random stream with gaps (R1, R8)
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            w = $urandom;
            if (i % 3 != 0) w[27:25] = 3'b101;
            drive(w, $urandom, 4'($urandom), "R3 random");
            if (i % 7 == 0) idle(1 + (i % 3));
        end
        idle(3);
        check("R1 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule